// File: doc/BRIEF.md
# One-Time-Programmable Fuse Array Controller

This block sits in front of a small one-time-programmable bit array, which is modelled here as a bank of internal registers. Software reaches it through a plain register bus. It sets a mode bit to take control, then writes a command code, a row address and one or two write-data words. It then raises a start bit and polls a status register until the command reports completion.

There are four commands: read a row, step the programming unlock, lock programming again, and program a row. Programming can only turn bits on. Before it has any effect, four unlock commands must complete, each carrying the next key value in a fixed sequence. A program command stays busy longer as its data sets more bits: the time is a fixed base plus a per-bit cost.

A parameter selects rows of one 32-bit word or two. With two words, a row is 64 bits and each address selects one whole row.

Top module: `fuse_array_ctrl`

## Requirements
- R1: The mode bit (offset 0x00, bit 0), the command field (offset 0x04, low 6 bits) and the row address (offset 0x28, low 16 bits) read back what was written. Upper bits written to these registers read as zero. Any offset with no register reads as zero.
- R2: A command launches only when bit 0 of the start register (offset 0x08) is written from 0 to 1 while mode bit 0 is 1. With mode bit 0 at 0, the done flag never rises.
- R3: Every command other than program raises done (status offset 0x0C, bit 1) exactly BUSY_BASE cycles after the launch edge. Writing 0 to start bit 0 clears done.
- R4: The read command (code 0x00) copies the addressed row into read-data word 0 (offset 0x10) and, for two-word rows, word 1 (offset 0x5C). Unprogrammed rows and rows at or beyond NUM_ROWS read as zero.
- R5: Programming becomes enabled (status bit 2) only after four unlock commands (code 0x02) complete with write-data word 0 equal to 0xF, 0x4, 0x8 and 0xD, in that order. The flag stays clear after the third.
- R6: An unlock command whose key differs from the expected next value sends the tracker back to its first step. That wrong value counts toward nothing.
- R7: A program command (code 0x08) issued while programming is not enabled completes and leaves the array unchanged.
- R8: When programming is enabled, a program command sets each row word to its old value OR the new data. Bits that are set are never cleared.
- R9: A program command is busy for BUSY_BASE + BUSY_PER_BIT × (number of ones across all write-data words of the row) cycles before done rises.
- R10: The lock command (code 0x03) clears status bit 2 in the same cycle that done rises.
- R11: A rising edge on the start bit while a command is busy is ignored. It neither restarts nor lengthens the running command.
- R12: Unlisted command codes only raise done after BUSY_BASE cycles. They change neither the array nor the programming flag.
- R13: With two-word rows, write-data word 1 sits at offset 0x64 and is programmed into the upper half of the row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe for one cycle |
| bus_addr | input | 8 | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |

## Verification
The program path is tried with data words of several weights: a few scattered bits, a nibble that adds to bits already set, and all ones in both words. The measured busy length therefore separates a correct per-bit cost from a fixed or per-word one, and a read-back after the second write separates OR-merging from overwriting. The unlock path is tried with a broken key sequence followed by the right one, and the flag is observed after every step. This shows whether a wrong value resets the tracker and whether the flag rises only on the fourth good key. Programs issued before unlock and after lock, an unknown code and a start pulse raised mid-busy show that these inputs leave the rows and the timing unchanged.

// File: rtl/fuse_pkg.sv
package fuse_pkg;

   localparam int WORD_W = 32;
   localparam int CMD_W  = 6;
   localparam int ADR_W  = 16;

   localparam logic [7:0] OFS_MODE   = 8'h00;
   localparam logic [7:0] OFS_CMD    = 8'h04;
   localparam logic [7:0] OFS_START  = 8'h08;
   localparam logic [7:0] OFS_STATUS = 8'h0C;
   localparam logic [7:0] OFS_ADDR   = 8'h28;

   typedef enum logic [CMD_W-1:0] {
      OP_READ   = 6'h00,
      OP_UNLOCK = 6'h02,
      OP_LOCK   = 6'h03,
      OP_PROG   = 6'h08
   } fuse_op_e;

   // read-data word offsets, word 0 first
   function automatic logic [7:0] rd_ofs(input int w);
      return (w == 0) ? 8'h10 : 8'h5C;
   endfunction

   // write-data word offsets, word 0 first
   function automatic logic [7:0] wd_ofs(input int w);
      return (w == 0) ? 8'h2C : 8'h64;
   endfunction

   // key expected at each unlock step
   function automatic logic [WORD_W-1:0] unlock_key(input logic [1:0] step);
      case (step)
         2'd0:    return 32'h0000_000F;
         2'd1:    return 32'h0000_0004;
         2'd2:    return 32'h0000_0008;
         default: return 32'h0000_000D;
      endcase
   endfunction

endpackage

// File: rtl/fuse_regs.sv
module fuse_regs
   import fuse_pkg::*;
#(
   parameter int ROW_WORDS = 1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        bus_wr,
   input  logic [7:0]                  bus_addr,
   input  logic [WORD_W-1:0]           bus_wdata,
   output logic [WORD_W-1:0]           bus_rdata,
   input  logic                        done,
   input  logic                        prog_en,
   input  logic [ROW_WORDS*WORD_W-1:0] rd_row,
   output logic                        mode_on,
   output logic [CMD_W-1:0]            cmd_q,
   output logic [ADR_W-1:0]            addr_q,
   output logic [ROW_WORDS*WORD_W-1:0] wd_row,
   output logic                        launch_req,
   output logic                        clr_done
);

   logic start_q;
   logic wr_start;

   assign wr_start   = bus_wr && (bus_addr == OFS_START);
   assign launch_req = wr_start && bus_wdata[0] && !start_q;
   assign clr_done   = wr_start && !bus_wdata[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_on <= 1'b0;
         start_q <= 1'b0;
         cmd_q   <= '0;
         addr_q  <= '0;
         wd_row  <= '0;
      end else if (bus_wr) begin
         if (bus_addr == OFS_MODE)  mode_on <= bus_wdata[0];
         if (bus_addr == OFS_START) start_q <= bus_wdata[0];
         if (bus_addr == OFS_CMD)   cmd_q   <= bus_wdata[CMD_W-1:0];
         if (bus_addr == OFS_ADDR)  addr_q  <= bus_wdata[ADR_W-1:0];
         for (int w = 0; w < ROW_WORDS; w++) begin
            if (bus_addr == wd_ofs(w)) wd_row[w*WORD_W +: WORD_W] <= bus_wdata;
         end
      end
   end

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         OFS_MODE:   bus_rdata = {{(WORD_W-1){1'b0}}, mode_on};
         OFS_START:  bus_rdata = {{(WORD_W-1){1'b0}}, start_q};
         OFS_CMD:    bus_rdata = {{(WORD_W-CMD_W){1'b0}}, cmd_q};
         OFS_ADDR:   bus_rdata = {{(WORD_W-ADR_W){1'b0}}, addr_q};
         OFS_STATUS: bus_rdata = {{(WORD_W-3){1'b0}}, prog_en, done, 1'b0};
         default:    bus_rdata = '0;
      endcase
      for (int w = 0; w < ROW_WORDS; w++) begin
         if (bus_addr == rd_ofs(w)) bus_rdata = rd_row[w*WORD_W +: WORD_W];
         if (bus_addr == wd_ofs(w)) bus_rdata = wd_row[w*WORD_W +: WORD_W];
      end
   end

endmodule

// File: rtl/fuse_seq.sv
module fuse_seq
   import fuse_pkg::*;
#(
   parameter int ROW_BITS     = 32,
   parameter int BUSY_BASE    = 4,
   parameter int BUSY_PER_BIT = 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                launch_req,
   input  logic                mode_on,
   input  logic                clr_done,
   input  logic [CMD_W-1:0]    cmd,
   input  logic [ADR_W-1:0]    addr,
   input  logic [ROW_BITS-1:0] data,
   output logic                busy,
   output logic                done,
   output logic [ADR_W-1:0]    cap_addr,
   output logic [ROW_BITS-1:0] cap_data,
   output logic                rd_fire,
   output logic                en_fire,
   output logic                dis_fire,
   output logic                pg_fire
);

   localparam int MAX_N = BUSY_BASE + BUSY_PER_BIT * ROW_BITS;
   localparam int CNT_W = $clog2(MAX_N + 1);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] load_n;
   logic [CMD_W-1:0] cap_cmd;
   logic             go;
   logic             fin;

   always_comb begin
      load_n = CNT_W'(BUSY_BASE);
      if (cmd == OP_PROG) load_n = CNT_W'(BUSY_BASE + BUSY_PER_BIT * $countones(data));
   end

   assign go  = launch_req && mode_on && !busy;
   assign fin = busy && (cnt_q == CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         done     <= 1'b0;
         cnt_q    <= '0;
         cap_cmd  <= '0;
         cap_addr <= '0;
         cap_data <= '0;
      end else if (go) begin
         busy     <= 1'b1;
         done     <= 1'b0;
         cnt_q    <= load_n;
         cap_cmd  <= cmd;
         cap_addr <= addr;
         cap_data <= data;
      end else if (busy) begin
         if (fin) begin
            busy <= 1'b0;
            done <= 1'b1;
         end else begin
            cnt_q <= cnt_q - CNT_W'(1);
         end
      end else if (clr_done) begin
         done <= 1'b0;
      end
   end

   assign rd_fire  = fin && (cap_cmd == OP_READ);
   assign en_fire  = fin && (cap_cmd == OP_UNLOCK);
   assign dis_fire = fin && (cap_cmd == OP_LOCK);
   assign pg_fire  = fin && (cap_cmd == OP_PROG);

endmodule

// File: rtl/fuse_unlock.sv
module fuse_unlock
   import fuse_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_fire,
   input  logic              dis_fire,
   input  logic [WORD_W-1:0] key,
   output logic              prog_en
);

   logic [1:0] step_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step_q  <= 2'd0;
         prog_en <= 1'b0;
      end else if (dis_fire) begin
         step_q  <= 2'd0;
         prog_en <= 1'b0;
      end else if (en_fire && !prog_en) begin
         if (key != unlock_key(step_q)) begin
            step_q <= 2'd0;
         end else if (step_q == 2'd3) begin
            step_q  <= 2'd0;
            prog_en <= 1'b1;
         end else begin
            step_q <= step_q + 2'd1;
         end
      end
   end

endmodule

// File: rtl/fuse_store.sv
module fuse_store
   import fuse_pkg::*;
#(
   parameter int ROW_BITS = 32,
   parameter int NUM_ROWS = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                rd_fire,
   input  logic                pg_fire,
   input  logic                prog_en,
   input  logic [ADR_W-1:0]    addr,
   input  logic [ROW_BITS-1:0] data,
   output logic [ROW_BITS-1:0] rd_row
);

   localparam int          IDX_W = $clog2(NUM_ROWS);
   localparam logic [ADR_W:0] DEPTH = (ADR_W+1)'(NUM_ROWS);

   logic                in_range;
   logic                wr_ok;
   logic [ROW_BITS-1:0] rows [NUM_ROWS];

   assign in_range = {1'b0, addr} < DEPTH;
   assign wr_ok    = pg_fire && prog_en && in_range;

   for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
      logic [ROW_BITS-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                 q <= '0;
         else if (wr_ok && addr == ADR_W'(r))        q <= q | data;
      end
      assign rows[r] = q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rd_row <= '0;
      else if (rd_fire) rd_row <= in_range ? rows[addr[IDX_W-1:0]] : '0;
   end

endmodule

// File: rtl/fuse_array_ctrl.sv
module fuse_array_ctrl
   import fuse_pkg::*;
#(
   parameter int ROW_WORDS    = 1,
   parameter int NUM_ROWS     = 16,
   parameter int BUSY_BASE    = 4,
   parameter int BUSY_PER_BIT = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [7:0]        bus_addr,
   input  logic [WORD_W-1:0] bus_wdata,
   output logic [WORD_W-1:0] bus_rdata
);

   localparam int ROW_BITS = ROW_WORDS * WORD_W;

   if (ROW_WORDS != 1 && ROW_WORDS != 2) begin : g_bad_words
      $error("ROW_WORDS must be 1 or 2");
   end
   if (NUM_ROWS < 2 || NUM_ROWS > 4096) begin : g_bad_rows
      $error("NUM_ROWS must lie in 2..4096");
   end
   if (BUSY_BASE < 1 || BUSY_PER_BIT < 0) begin : g_bad_busy
      $error("BUSY_BASE must be at least 1 and BUSY_PER_BIT not negative");
   end

   logic                mode_on;
   logic [CMD_W-1:0]    cmd_q;
   logic [ADR_W-1:0]    addr_q;
   logic [ROW_BITS-1:0] wd_row;
   logic [ROW_BITS-1:0] rd_row;
   logic                launch_req;
   logic                clr_done;
   logic                busy;
   logic                done;
   logic                prog_en;
   logic [ADR_W-1:0]    cap_addr;
   logic [ROW_BITS-1:0] cap_data;
   logic                rd_fire;
   logic                en_fire;
   logic                dis_fire;
   logic                pg_fire;

   fuse_regs #(.ROW_WORDS(ROW_WORDS)) i_regs (
      .clk, .rst_n, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata,
      .done, .prog_en, .rd_row, .mode_on, .cmd_q, .addr_q, .wd_row,
      .launch_req, .clr_done
   );

   fuse_seq #(
      .ROW_BITS(ROW_BITS), .BUSY_BASE(BUSY_BASE), .BUSY_PER_BIT(BUSY_PER_BIT)
   ) i_seq (
      .clk, .rst_n, .launch_req, .mode_on, .clr_done,
      .cmd(cmd_q), .addr(addr_q), .data(wd_row),
      .busy, .done, .cap_addr, .cap_data,
      .rd_fire, .en_fire, .dis_fire, .pg_fire
   );

   fuse_unlock i_unlock (
      .clk, .rst_n, .en_fire, .dis_fire,
      .key(cap_data[WORD_W-1:0]), .prog_en
   );

   fuse_store #(.ROW_BITS(ROW_BITS), .NUM_ROWS(NUM_ROWS)) i_store (
      .clk, .rst_n, .rd_fire, .pg_fire, .prog_en,
      .addr(cap_addr), .data(cap_data), .rd_row
   );

endmodule

// File: rtl/fuse_array_ctrl_chk.sv
module fuse_array_ctrl_chk (
   input logic clk,
   input logic rst_n,
   input logic mode_on,
   input logic launch_req,
   input logic clr_done,
   input logic busy,
   input logic done,
   input logic prog_en,
   input logic en_fire,
   input logic dis_fire
);

   // R3: busy and done are never seen together
   p_busy_done_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy && done));

   // R2: an accepted launch makes the block busy
   p_launch_taken_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (launch_req && mode_on && !busy) |=> busy);

   // R2: without the mode bit an idle block stays idle
   p_mode_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !mode_on) |=> !busy);

   // R11: a running command only ends in done, never vanishes
   p_busy_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> (busy || done));

   // R3: clearing start while idle drops done
   p_done_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_done && !busy) |=> !done);

   // R5: programming is enabled only by an unlock completion
   p_unlock_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(prog_en) |-> $past(en_fire));

   // R10: a lock completion leaves programming disabled
   p_lock_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
      dis_fire |=> !prog_en);

   // R10: programming is disabled only by a lock completion
   p_lock_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(prog_en) |-> $past(dis_fire));

endmodule

bind fuse_array_ctrl fuse_array_ctrl_chk i_chk (
   .clk(clk), .rst_n(rst_n), .mode_on(mode_on), .launch_req(launch_req),
   .clr_done(clr_done), .busy(busy), .done(done), .prog_en(prog_en),
   .en_fire(en_fire), .dis_fire(dis_fire)
);

// File: tb/test_fuse_array_ctrl.sv
`timescale 1ns/1ps
module test_fuse_array_ctrl;

   localparam int BASE = 4;
   localparam int PERB = 2;

   localparam logic [7:0] A_MODE = 8'h00, A_CMD = 8'h04, A_START = 8'h08,
                          A_STAT = 8'h0C, A_ADDR = 8'h28, A_RD0 = 8'h10,
                          A_RD1 = 8'h5C, A_WD0 = 8'h2C, A_WD1 = 8'h64;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = 8'h00;
   logic [31:0] bus_wdata = 32'h0;
   logic [31:0] bus_rdata;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   fuse_array_ctrl #(
      .ROW_WORDS(2), .NUM_ROWS(16), .BUSY_BASE(BASE), .BUSY_PER_BIT(PERB)
   ) i_fuse_array_ctrl (
      .clk, .rst_n, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
   endtask

   // issue a command, count cycles until done, then clear start
   task automatic run_cmd(input logic [5:0] c, input logic [31:0] ad,
                          input logic [31:0] d0, input logic [31:0] d1,
                          output int cyc, output logic [31:0] st);
      wr(A_CMD, {26'd0, c});
      wr(A_ADDR, ad);
      wr(A_WD0, d0);
      wr(A_WD1, d1);
      wr(A_START, 32'h1);
      bus_addr = A_STAT;
      cyc = 0;
      st  = 32'h0;
      for (int k = 1; k <= 400; k++) begin
         @(negedge clk);
         #1;
         if (bus_rdata[1]) begin
            cyc = k;
            st  = bus_rdata;
            break;
         end
      end
      wr(A_START, 32'h0);
   endtask

   task automatic read_row(input logic [31:0] ad, output logic [31:0] w0, output logic [31:0] w1);
      int          c;
      logic [31:0] s;
      run_cmd(6'h00, ad, 32'h0, 32'h0, c, s);
      rd(A_RD0, w0);
      rd(A_RD1, w1);
   endtask

   task automatic t_reset();
      logic [31:0] v;
      rd(A_STAT, v);  chk("R3 reset status", v, 32'h0);
      rd(A_MODE, v);  chk("R1 reset mode", v, 32'h0);
      rd(A_RD0, v);   chk("R4 reset read word", v, 32'h0);
   endtask

   task automatic t_regs();
      logic [31:0] v;
      wr(A_MODE, 32'hFFFF_FFFF);  rd(A_MODE, v);  chk("R1 mode readback", v, 32'h1);
      wr(A_CMD, 32'h0000_00FF);   rd(A_CMD, v);   chk("R1 command width", v, 32'h3F);
      wr(A_ADDR, 32'hABCD_1234);  rd(A_ADDR, v);  chk("R1 address width", v, 32'h1234);
      rd(8'h20, v);                                chk("R1 unused offset", v, 32'h0);
      wr(A_WD1, 32'h1357_9BDF);   rd(A_WD1, v);   chk("R13 second write word", v, 32'h1357_9BDF);
   endtask

   task automatic t_mode_gate();
      logic [31:0] v;
      logic        seen = 1'b0;
      wr(A_MODE, 32'h0);
      wr(A_CMD, 32'h0);
      wr(A_START, 32'h1);
      bus_addr = A_STAT;
      for (int k = 0; k < 30; k++) begin
         @(negedge clk);
         #1 if (bus_rdata[1]) seen = 1'b1;
      end
      chk("R2 no launch with mode off", {31'd0, seen}, 32'h0);
      wr(A_START, 32'h0);
      wr(A_MODE, 32'h1);
      rd(A_STAT, v);
      chk("R2 status idle after mode on", v, 32'h0);
   endtask

   task automatic t_read_blank();
      int          c;
      logic [31:0] s, v, w0, w1;
      run_cmd(6'h00, 32'd3, 32'h0, 32'h0, c, s);
      chk("R3 read busy length", c, BASE);
      rd(A_STAT, v);
      chk("R3 done cleared by start 0", v, 32'h0);
      rd(A_RD0, w0);  chk("R4 blank row word0", w0, 32'h0);
      rd(A_RD1, w1);  chk("R4 blank row word1", w1, 32'h0);
   endtask

   task automatic t_prog_locked();
      int          c;
      logic [31:0] s, w0, w1;
      run_cmd(6'h08, 32'd3, 32'hA5A5_A5A5, 32'h0000_000F, c, s);
      chk("R9 locked program busy length", c, BASE + PERB * 20);
      chk("R7 status after locked program", s, 32'h2);
      read_row(32'd3, w0, w1);
      chk("R7 row unchanged word0", w0, 32'h0);
      chk("R7 row unchanged word1", w1, 32'h0);
   endtask

   task automatic t_unknown();
      int          c;
      logic [31:0] s;
      run_cmd(6'h15, 32'd3, 32'hFFFF_FFFF, 32'hFFFF_FFFF, c, s);
      chk("R12 unknown code length", c, BASE);
      chk("R12 unknown code status", s, 32'h2);
   endtask

   task automatic t_unlock();
      int          c;
      logic [31:0] s;
      logic [31:0] bad [5] = '{32'hF, 32'h4, 32'h7, 32'h8, 32'hD};
      logic [31:0] good [4] = '{32'hF, 32'h4, 32'h8, 32'hD};
      for (int i = 0; i < 5; i++) begin
         run_cmd(6'h02, 32'd0, bad[i], 32'h0, c, s);
         chk("R6 broken sequence keeps flag clear", s, 32'h2);
      end
      for (int i = 0; i < 4; i++) begin
         run_cmd(6'h02, 32'd0, good[i], 32'h0, c, s);
         chk("R3 unlock step length", c, BASE);
         chk("R5 flag after unlock step", s, (i == 3) ? 32'h6 : 32'h2);
      end
   endtask

   task automatic t_prog();
      int          c;
      logic [31:0] s, w0, w1;
      run_cmd(6'h08, 32'd5, 32'h0000_00F0, 32'h8000_0001, c, s);
      chk("R9 six-bit program length", c, BASE + PERB * 6);
      read_row(32'd5, w0, w1);
      chk("R8 first program word0", w0, 32'h0000_00F0);
      chk("R13 first program word1", w1, 32'h8000_0001);
      run_cmd(6'h08, 32'd5, 32'h0000_000F, 32'h0000_0000, c, s);
      chk("R9 four-bit program length", c, BASE + PERB * 4);
      read_row(32'd5, w0, w1);
      chk("R8 merged word0", w0, 32'h0000_00FF);
      chk("R8 merged word1 kept", w1, 32'h8000_0001);
      run_cmd(6'h08, 32'd7, 32'hFFFF_FFFF, 32'hFFFF_FFFF, c, s);
      chk("R9 all-ones program length", c, BASE + PERB * 64);
      read_row(32'd7, w0, w1);
      chk("R13 all-ones word1", w1, 32'hFFFF_FFFF);
      run_cmd(6'h08, 32'd20, 32'h1, 32'h1, c, s);
      read_row(32'd20, w0, w1);
      chk("R4 out-of-range row reads zero", w0 | w1, 32'h0);
   endtask

   task automatic t_busy_ignore();
      int          c = 0;
      logic [31:0] w0, w1;
      wr(A_CMD, 32'h08);
      wr(A_ADDR, 32'd9);
      wr(A_WD0, 32'h0000_FFFF);
      wr(A_WD1, 32'h0);
      wr(A_START, 32'h1);
      bus_addr = A_STAT;
      for (int k = 1; k <= 400; k++) begin
         @(negedge clk);
         if (k == 5) begin
            bus_wr = 1'b1; bus_addr = A_START; bus_wdata = 32'h0;
         end else if (k == 6) begin
            bus_wdata = 32'h1;
         end else if (k == 7) begin
            bus_wr = 1'b0; bus_addr = A_STAT;
         end else if (k > 7) begin
            #1 if (bus_rdata[1]) begin
               c = k;
               break;
            end
         end
      end
      wr(A_START, 32'h0);
      chk("R11 mid-busy start pulse ignored", c, BASE + PERB * 16);
      read_row(32'd9, w0, w1);
      chk("R11 row after ignored pulse", w0, 32'h0000_FFFF);
   endtask

   task automatic t_lock();
      int          c;
      logic [31:0] s, w0, w1;
      run_cmd(6'h03, 32'd0, 32'h0, 32'h0, c, s);
      chk("R10 lock length", c, BASE);
      chk("R10 flag clear when done", s, 32'h2);
      run_cmd(6'h08, 32'd3, 32'hFF, 32'hFF, c, s);
      read_row(32'd3, w0, w1);
      chk("R7 program after lock ignored", w0 | w1, 32'h0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_regs();
      t_mode_gate();
      t_read_blank();
      t_prog_locked();
      t_unknown();
      t_unlock();
      t_prog();
      t_busy_ignore();
      t_lock();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule